// File: doc/BRIEF.md
# Non-Overlapping Pulse Pattern Generator

This block drives an 8-bit output pattern, paced by a free-running timer with two compare points. The period compare marks the start of each output period and clears the counter. The margin compare, placed inside the period, is a second point at which output bits may go high. A pattern update splits its changes by direction. Bits that go low are applied at the period match. Bits that go high stay low until the margin match. So, for bit pairs driving complementary switches, one phase has always dropped before the other rises.

Software or a DMA engine loads the next pattern into a buffer through a small register write port. The block samples that buffer at each period match. It raises a one-cycle request at the margin match so the buffer can be refilled in time for the next period. Non-overlap mode is selected separately for each 4-bit output group. A group with the mode off takes its whole new value at the period match. A per-bit enable decides which outputs the pattern logic may change.

Top module: `nov_pulse_gen`

## Requirements
- R1: The counter starts at 0 after reset and counts up by one each cycle. In any cycle where it is greater than or equal to the period register (address 0), it returns to 0 on the next edge. With period P, period matches therefore come every P+1 cycles.
- R2: In a group with non-overlap mode on, an enabled output bit that is 1 and whose sampled next-data bit is 0 falls on the clock edge of the period match.
- R3: In a group with non-overlap mode on, when the margin register (address 1) is below the period, an enabled bit going from 0 to 1 stays 0 through the period match. It rises on the edge of the cycle in which the counter equals the margin.
- R4: Mode register (address 4) bit g turns on non-overlap mode for outputs 4g+3..4g. A group with its mode bit 0 loads all of its enabled bits from next data at the period-match edge.
- R5: An output whose bit in the enable register (address 3) is 0 keeps its value.
- R6: The next-data register (address 2) is sampled on the period-match edge. A write on or after that edge affects only the following period.
- R7: When the request-enable register (address 5, bit 0) is 1, the request output is high for exactly one cycle, the cycle after the margin match. When that bit is 0, the request output stays low.
- R8: If the margin is greater than or equal to the period, pending rises in a non-overlap group are applied at the next period match, provided the new next-data bit is still 1. The request is then raised once per period, in the cycle after the period match.
- R9: A synchronous active-high reset clears the counter, the outputs, all registers, pending rises and the request.
- R10: With both groups in non-overlap mode, loading 0x95, 0x65, 0x59, 0x56 and repeating, one value per request, makes the output equal the loaded value in each request cycle. No cycle has one bit rising while another falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | CNT_W (16) | Write data |
| pattern_o | output | OUT_W (8) | Pulse pattern outputs |
| req_o | output | 1 | Refill request pulse |

## Verification
A wrong counter value moves every output edge and every request. It shows at the ports within one period of P+1 cycles, because the request spacing and the fall times shift together. A corrupt pending-rise mask shows as a bit rising at the period match instead of at the margin match, or never rising. That is visible in the same period. A mis-sampled next-data buffer shows in the first period after the late write. A cycle-accurate bench model of the requirements is compared with both outputs in every cycle, so each of these appears on the first cycle it differs.

// File: rtl/npg_pkg.sv
package npg_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      SEL_PERIOD = 3'd0,
      SEL_MARGIN = 3'd1,
      SEL_NEXT   = 3'd2,
      SEL_OEN    = 3'd3,
      SEL_GMODE  = 3'd4,
      SEL_REQEN  = 3'd5
   } reg_sel_e;
endpackage

// File: rtl/npg_regs.sv
module npg_regs
   import npg_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int OUT_W = 8,
   parameter int NGRP  = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] period_q,
   output logic [CNT_W-1:0] margin_q,
   output logic [OUT_W-1:0] next_q,
   output logic [OUT_W-1:0] oen_q,
   output logic [NGRP-1:0]  gmode_q,
   output logic             reqen_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         period_q <= '0;
         margin_q <= '0;
         next_q   <= '0;
         oen_q    <= '0;
         gmode_q  <= '0;
         reqen_q  <= 1'b0;
      end else if (wr_en) begin
         case (reg_sel_e'(wr_addr))
            SEL_PERIOD: period_q <= wr_data;
            SEL_MARGIN: margin_q <= wr_data;
            SEL_NEXT:   next_q   <= wr_data[OUT_W-1:0];
            SEL_OEN:    oen_q    <= wr_data[OUT_W-1:0];
            SEL_GMODE:  gmode_q  <= wr_data[NGRP-1:0];
            SEL_REQEN:  reqen_q  <= wr_data[0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/npg_timer.sv
module npg_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] margin_i,
   output logic             period_hit_o,
   output logic             margin_hit_o,
   output logic             margin_ok_o
);
   logic [CNT_W-1:0] cnt_q;

   assign period_hit_o = (cnt_q >= period_i);
   assign margin_ok_o  = (margin_i < period_i);
   assign margin_hit_o = margin_ok_o && (cnt_q == margin_i);

   always_ff @(posedge clk) begin
      if (rst)               cnt_q <= '0;
      else if (period_hit_o) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   // R1
   cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      period_hit_o |=> (cnt_q == '0));

   // R1
   cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
      !period_hit_o |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/npg_group.sv
module npg_group #(
   parameter int GW      = 4,
   parameter bit NOV_CAP = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          period_hit_i,
   input  logic          margin_hit_i,
   input  logic          nov_i,
   input  logic [GW-1:0] next_i,
   input  logic [GW-1:0] oen_i,
   output logic [GW-1:0] out_o
);
   logic [GW-1:0] out_q, out_d;

   generate
      if (NOV_CAP) begin : g_nov
         logic [GW-1:0] rise_q, rise_d;

         always_comb begin
            out_d  = out_q;
            rise_d = rise_q;
            if (period_hit_i) begin
               if (nov_i) begin
                  out_d  = (oen_i & next_i & (out_q | rise_q)) | (~oen_i & out_q);
                  rise_d = oen_i & next_i & ~(out_q | rise_q);
               end else begin
                  out_d  = (oen_i & next_i) | (~oen_i & out_q);
                  rise_d = '0;
               end
            end else if (margin_hit_i) begin
               out_d  = out_q | rise_q;
               rise_d = '0;
            end
         end

         always_ff @(posedge clk) begin
            if (rst) rise_q <= '0;
            else     rise_q <= rise_d;
         end
      end else begin : g_plain
         always_comb begin
            out_d = out_q;
            if (period_hit_i) out_d = (oen_i & next_i) | (~oen_i & out_q);
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) out_q <= '0;
      else     out_q <= out_d;
   end

   assign out_o = out_q;

   // R2
   fall_at_period_chk: assert property (@(posedge clk) disable iff (rst)
      (|($past(out_q) & ~out_q)) |-> $past(period_hit_i));

   // R3
   rise_at_margin_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(nov_i) && !$past(period_hit_i) && (|(~$past(out_q) & out_q)))
      |-> $past(margin_hit_i));

   // R5
   oen_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ((~$past(oen_i)) & ($past(out_q) ^ out_q)) == '0);
endmodule

// File: rtl/nov_pulse_gen.sv
module nov_pulse_gen
   import npg_pkg::*;
#(
   parameter int          CNT_W      = 16,
   parameter int          OUT_W      = 8,
   parameter int          GRP_W      = 4,
   parameter int unsigned NOV_GROUPS = 32'hFFFF_FFFF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [OUT_W-1:0]  pattern_o,
   output logic              req_o
);
   localparam int NGRP = OUT_W / GRP_W;

   generate
      if (OUT_W % GRP_W != 0) begin : g_bad_grp
         $error("OUT_W must be a multiple of GRP_W");
      end
      if (CNT_W < OUT_W || NGRP > 32) begin : g_bad_cnt
         $error("CNT_W must cover OUT_W and NGRP must fit the mask");
      end
   endgenerate

   logic [CNT_W-1:0] period_q, margin_q;
   logic [OUT_W-1:0] next_q, oen_q;
   logic [NGRP-1:0]  gmode_q;
   logic             reqen_q;
   logic             period_hit, margin_hit, margin_ok;
   logic             req_q;

   npg_regs #(.CNT_W(CNT_W), .OUT_W(OUT_W), .NGRP(NGRP)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .period_q(period_q), .margin_q(margin_q), .next_q(next_q),
      .oen_q(oen_q), .gmode_q(gmode_q), .reqen_q(reqen_q)
   );

   npg_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst(rst), .period_i(period_q), .margin_i(margin_q),
      .period_hit_o(period_hit), .margin_hit_o(margin_hit), .margin_ok_o(margin_ok)
   );

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      npg_group #(.GW(GRP_W), .NOV_CAP(((NOV_GROUPS >> g) & 1) != 0)) u_grp (
         .clk(clk), .rst(rst),
         .period_hit_i(period_hit), .margin_hit_i(margin_hit),
         .nov_i(gmode_q[g]),
         .next_i(next_q[g*GRP_W +: GRP_W]),
         .oen_i(oen_q[g*GRP_W +: GRP_W]),
         .out_o(pattern_o[g*GRP_W +: GRP_W])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) req_q <= 1'b0;
      else     req_q <= reqen_q & (margin_ok ? margin_hit : period_hit);
   end

   assign req_o = req_q;

   // R7
   req_single_chk: assert property (@(posedge clk) disable iff (rst)
      (req_q && period_q != '0) |=> !req_q);

   // R7
   req_gate_chk: assert property (@(posedge clk) disable iff (rst)
      req_q |-> $past(reqen_q));
endmodule

// File: tb/tb_nov_pulse_gen.sv
`timescale 1ns/1ps
module tb_nov_pulse_gen;
   localparam int CNT_W = 16;
   localparam int OUT_W = 8;
   localparam int GRP_W = 4;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             wr_en = 1'b0;
   logic [2:0]       wr_addr = '0;
   logic [CNT_W-1:0] wr_data = '0;
   logic [OUT_W-1:0] pattern_o;
   logic             req_o;

   int n_chk = 0;
   int n_bad = 0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   nov_pulse_gen #(.CNT_W(CNT_W), .OUT_W(OUT_W), .GRP_W(GRP_W)) dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pattern_o(pattern_o), .req_o(req_o)
   );

   // reference model built from the requirements
   logic [CNT_W-1:0] m_cnt, m_per, m_mar;
   logic [OUT_W-1:0] m_ndr, m_oe, m_out, m_rise;
   logic [1:0]       m_mode;
   logic             m_ren, m_req;

   always @(posedge clk) begin
      logic hit, mok, mhit;
      logic [OUT_W-1:0] n_out, n_rise;
      if (rst) begin
         m_cnt = '0; m_per = '0; m_mar = '0; m_ndr = '0; m_oe = '0;
         m_out = '0; m_rise = '0; m_mode = '0; m_ren = 1'b0; m_req = 1'b0;
      end else begin
         hit  = (m_cnt >= m_per);
         mok  = (m_mar < m_per);
         mhit = mok && (m_cnt == m_mar);
         n_out = m_out; n_rise = m_rise;
         if (hit) begin
            for (int i = 0; i < OUT_W; i++) begin
               if (!m_oe[i]) n_rise[i] = 1'b0;
               else if (m_mode[i/GRP_W]) begin
                  n_out[i]  = m_ndr[i] & (m_out[i] | m_rise[i]);
                  n_rise[i] = m_ndr[i] & ~n_out[i];
               end else begin
                  n_out[i]  = m_ndr[i];
                  n_rise[i] = 1'b0;
               end
            end
         end else if (mhit) begin
            n_out  = m_out | m_rise;
            n_rise = '0;
         end
         m_req  = m_ren & (mok ? mhit : hit);
         m_out  = n_out;
         m_rise = n_rise;
         m_cnt  = hit ? '0 : m_cnt + 1'b1;
         if (wr_en) begin
            case (wr_addr)
               3'd0: m_per  = wr_data;
               3'd1: m_mar  = wr_data;
               3'd2: m_ndr  = wr_data[OUT_W-1:0];
               3'd3: m_oe   = wr_data[OUT_W-1:0];
               3'd4: m_mode = wr_data[1:0];
               3'd5: m_ren  = wr_data[0];
               default: ;
            endcase
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_on && !rst) begin
         check(pattern_o == m_out, "R1/R2/R3/R4/R5/R6/R8 pattern", pattern_o, m_out);
         check(req_o == m_req, "R7/R8 request", req_o, m_req);
      end
   end

   task automatic wr(input logic [2:0] a, input logic [CNT_W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic config_all(input int per, input int mar, input int mode,
                             input int oe, input int ren);
      wr(3'd0, CNT_W'(per));
      wr(3'd1, CNT_W'(mar));
      wr(3'd4, CNT_W'(mode));
      wr(3'd3, CNT_W'(oe));
      wr(3'd5, CNT_W'(ren));
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         summary();
      end
   end

   initial begin
      logic [7:0] seq [4];
      int k, reqs;
      logic [7:0] prev;
      void'($urandom(32'd20251));
      seq[0] = 8'h95; seq[1] = 8'h65; seq[2] = 8'h59; seq[3] = 8'h56;

      // R9: reset state
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(pattern_o == 8'h00, "R9 reset pattern", pattern_o, 0);
      check(req_o == 1'b0, "R9 reset request", req_o, 0);
      cmp_on = 1'b1;

      // R10: four-phase sequence with dead time
      config_all(9, 3, 3, 8'hFF, 1);
      wr(3'd2, 16'h0095);
      k = 0;
      prev = pattern_o;
      while (k < 12) begin
         @(negedge clk);
         check(!((|(prev & ~pattern_o)) && (|(~prev & pattern_o))),
               "R10 dead time", pattern_o, prev);
         prev = pattern_o;
         if (req_o) begin
            if (k > 0) check(pattern_o == seq[k % 4], "R10 phase value", pattern_o, seq[k % 4]);
            wr_en = 1'b1; wr_addr = 3'd2; wr_data = {8'h00, seq[(k + 1) % 4]};
            @(negedge clk);
            wr_en = 1'b0;
            check(!((|(prev & ~pattern_o)) && (|(~prev & pattern_o))),
                  "R10 dead time", pattern_o, prev);
            prev = pattern_o;
            k++;
         end
      end

      // R6: late write affects only the following period
      do_reset();
      config_all(5, 2, 0, 8'hFF, 0);
      wr(3'd2, 16'h00A5);
      k = 0;
      while (pattern_o != 8'hA5 && k < 20) begin @(negedge clk); k++; end
      check(pattern_o == 8'hA5, "R4 group load", pattern_o, 8'hA5);
      wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'h003C;
      @(negedge clk);
      wr_en = 1'b0;
      repeat (2) @(negedge clk);
      check(pattern_o == 8'hA5, "R6 held until next period", pattern_o, 8'hA5);
      repeat (4) @(negedge clk);
      check(pattern_o == 8'h3C, "R6 applied next period", pattern_o, 8'h3C);

      // R7: request disabled stays low
      reqs = 0;
      for (int c = 0; c < 30; c++) begin @(negedge clk); if (req_o) reqs++; end
      check(reqs == 0, "R7 request disabled", reqs, 0);

      // R8: degenerate margin
      do_reset();
      config_all(4, 8, 3, 8'hFF, 1);
      wr(3'd2, 16'h000F);
      reqs = 0;
      for (int c = 0; c < 50; c++) begin @(negedge clk); if (req_o) reqs++; end
      check(reqs == 10, "R8 one request per period", reqs, 10);
      check(pattern_o == 8'h0F, "R8 late rise applied", pattern_o, 8'h0F);

      // R9: reset clears after activity
      do_reset();
      check(pattern_o == 8'h00, "R9 reset clears pattern", pattern_o, 0);
      check(req_o == 1'b0, "R9 reset clears request", req_o, 0);

      // random segments covering R1 R2 R3 R4 R5 R6 R8
      for (int s = 0; s < 30; s++) begin
         do_reset();
         config_all(2 + ($urandom % 11), $urandom % 15, $urandom % 4,
                    $urandom % 256, $urandom % 2);
         for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            if (($urandom % 10) < 3) begin
               wr_en = 1'b1; wr_addr = 3'd2; wr_data = CNT_W'($urandom % 256);
            end else begin
               wr_en = 1'b0;
            end
         end
         @(negedge clk);
         wr_en = 1'b0;
      end

      cmp_on = 1'b0;
      done = 1'b1;
      summary();
   end
endmodule